// File: doc/BRIEF.md
# Single-Wire Slave Addressing Layer

This block sits in a single-wire slave device between the bit-slot decoder and the function layer. The decoder hands it three kinds of event, each a one-cycle strobe: a bus reset, a write slot carrying one data bit, and a read slot that takes the bit the block offers on `rd_bit`. After every bus reset the block gathers an 8-bit addressing command, least significant bit first. It then runs that command against a fixed 64-bit device identity.

Five commands are understood. Read ID sends the identity out. Match ID compares 64 incoming bits against the identity. Skip ID addresses the device without any exchange. Search and Alarm Search walk the identity one bit at a time. When addressing succeeds, `selected` rises and later write slots are passed to the function layer. After a failed match, a finished or lost search, an unknown code, or an Alarm Search with no alarm pending, the device stays quiet. It returns 1 on every read slot until the next bus reset.

The identity is built when the block is elaborated. A family byte sits in the low 8 bits, a 48-bit serial number above it, and an 8-bit CRC of those 56 bits in the top byte.

Top module: `ow_rom_layer`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, `selected` and `fn_bit_valid` are 0 and `rd_bit` is 1. A low `rst_n` in the middle of a transaction deselects the device.
- R2: After a bus reset, eight write slots form the command, first slot in bit 0. The codes are Search F0h, Read ID 33h, Match ID 55h, Skip ID CCh and Alarm Search ECh.
- R3: The identity is {CRC, SERIAL, FAMILY} with FAMILY in bits 7:0 and SERIAL in bits 55:8. The CRC in bits 63:56 uses polynomial x^8+x^5+x^4+1, starts from 0 and takes the 56 lower bits bit 0 first. Read ID answers 64 read slots with identity bits 0 to 63 in order, and `selected` rises after the 64th slot.
- R4: Match ID followed by 64 write slots equal to identity bits 0 to 63 raises `selected` after the 64th slot and not before. `selected` then holds until a bus reset or `rst_n`.
- R5: A Match ID bit that differs from the identity stops the match. `selected` stays 0, every read slot returns 1 and no `fn_bit_valid` appears until the next bus reset.
- R6: Skip ID raises `selected` in the cycle after the eighth command slot.
- R7: In Search, each identity bit takes two read slots (the bit, then its complement) and then one write slot. A write bit that differs drops the device out, and later read slots return 1. After all 64 bits match, the device goes quiet (not selected) until a bus reset.
- R8: Alarm Search behaves as Search when `alarm_flag` is 1 in the cycle the eighth command bit arrives. Otherwise the device goes quiet.
- R9: Any other command code leaves the device quiet (reads return 1, not selected, no `fn_bit_valid`) until a bus reset.
- R10: While selected, each write slot gives `fn_bit_valid`=1 in the next cycle, with `fn_bit` equal to the written bit. `fn_bit_valid` is never 1 otherwise.
- R11: While collecting a command or while selected, read slots return 1.
- R12: A bus reset returns the device to command collection from any state. It wins over a write or read slot in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | One-cycle strobe: bus reset pulse detected |
| wr_stb | input | 1 | One-cycle strobe: a write slot completed |
| wr_bit | input | 1 | Data bit of the write slot |
| rd_req | input | 1 | One-cycle strobe: a read slot takes `rd_bit` |
| alarm_flag | input | 1 | Alarm condition from the measurement logic |
| rd_bit | output | 1 | Bit offered for the next read slot (1 releases the bus) |
| selected | output | 1 | Device addressed; function layer owns later slots |
| fn_bit_valid | output | 1 | A write-slot bit is passed to the function layer |
| fn_bit | output | 1 | The passed bit |

## Verification
The assertions check on every cycle the invariants that hold for any stimulus:
- a bus reset deselects the device;
- pass-through pulses occur only after a write slot taken while selected, and carry that slot's bit;
- selection holds once gained and is entered only on a slot;
- the quiet state holds and always releases the bus.

Several behaviours need the bench's scenarios, because they depend on the identity value and on bit order. These are the exact identity bit stream with its computed CRC, the exact slot in which Match ID selects, the bit/complement pairs of a search, and the outcome of every one of the 256 command codes.

// File: rtl/ow_rom_pkg.sv
// Package ow_rom_pkg
// Shared constants, state types and identity helpers for the single-wire
// addressing layer. Assumes a 64-bit identity of 8 + 48 + 8 bits.
package ow_rom_pkg;

    localparam int ID_W    = 64;
    localparam int CMD_W   = 8;
    localparam int FAM_W   = 8;
    localparam int SER_W   = 48;
    localparam int CRC_W   = ID_W - FAM_W - SER_W;
    localparam int BODY_W  = FAM_W + SER_W;
    localparam int IDX_W   = $clog2(ID_W);

    localparam logic [CMD_W-1:0] CMD_SEARCH = 8'hF0;
    localparam logic [CMD_W-1:0] CMD_READ   = 8'h33;
    localparam logic [CMD_W-1:0] CMD_MATCH  = 8'h55;
    localparam logic [CMD_W-1:0] CMD_SKIP   = 8'hCC;
    localparam logic [CMD_W-1:0] CMD_ALARM  = 8'hEC;

    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 8'h8C;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_SEARCH,
        ST_SEL,
        ST_MUTE
    } rom_state_e;

    typedef enum logic [1:0] {
        PH_TRUE,
        PH_COMP,
        PH_DIR
    } srch_phase_e;

    // CRC over the identity body, bit 0 first, register starting at zero.
    function automatic logic [CRC_W-1:0] body_crc(input logic [BODY_W-1:0] body);
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = '0;
        for (int i = 0; i < BODY_W; i++) begin
            fb  = acc[0] ^ body[i];
            acc = acc >> 1;
            if (fb) acc = acc ^ CRC_POLY_REFL;
        end
        return acc;
    endfunction

    // Assemble {crc, serial, family}.
    function automatic logic [ID_W-1:0] build_id(input logic [FAM_W-1:0] fam,
                                                 input logic [SER_W-1:0] ser);
        logic [BODY_W-1:0] body;
        body = {ser, fam};
        return {body_crc(body), body};
    endfunction

endpackage

// File: rtl/ow_cmd_collect.sv
// Module ow_cmd_collect
// Gathers a command word from write slots, first bit into bit 0.
// Presents the complete word in the same cycle as its last bit, together
// with a done flag. Assumes the caller enables shifting only while a
// command is expected. The count wraps on its own after each word.
module ow_cmd_collect #(
    parameter int CMD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic             done,
    output logic [CMD_W-1:0] code
);
    localparam int            CW   = $clog2(CMD_W);
    localparam logic [CW-1:0] LAST = CW'(CMD_W - 1);

    logic [CW-1:0]    cnt;
    logic [CMD_W-1:0] shreg;

    // Shift the incoming bit in from the top and count the slots.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (shift_en) begin
            shreg <= {bit_in, shreg[CMD_W-1:1]};
            cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    // The word is complete when the last slot arrives.
    always_comb begin
        done = shift_en && (cnt == LAST);
        code = {bit_in, shreg[CMD_W-1:1]};
    end

endmodule

// File: rtl/ow_id_index.sv
// Module ow_id_index
// Bit pointer into the identity. It is cleared when a command starts and
// stepped once per exchanged bit, and it flags the final bit position.
module ow_id_index #(
    parameter int ID_W = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    step,
    output logic [$clog2(ID_W)-1:0] idx,
    output logic                    last
);
    localparam int             IW  = $clog2(ID_W);
    localparam logic [IW-1:0]  TOP = IW'(ID_W - 1);

    // Advance the pointer; clear takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) idx <= '0;
        else if (step)       idx <= idx + 1'b1;
    end

    // Final position marker.
    always_comb last = (idx == TOP);

endmodule

// File: rtl/ow_rom_fsm.sv
// Module ow_rom_fsm
// Sequencer for the addressing commands. It chooses the read-slot answer,
// decides selection and passes write bits to the function layer once
// selected. Assumes strobes last one cycle and that a bus reset strobe
// outranks any slot strobe in the same cycle.
module ow_rom_fsm
    import ow_rom_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_reset,
    input  logic             wr_stb,
    input  logic             wr_bit,
    input  logic             rd_req,
    input  logic             alarm_flag,
    input  logic             cmd_done,
    input  logic [CMD_W-1:0] cmd_code,
    input  logic             id_bit,
    input  logic             idx_last,
    output logic             cmd_shift,
    output logic             idx_clear,
    output logic             idx_step,
    output rom_state_e       state,
    output logic             rd_bit,
    output logic             selected,
    output logic             fn_bit_valid,
    output logic             fn_bit
);
    rom_state_e  st_n;
    srch_phase_e phase, ph_n;

    // Next state, pointer control and phase of the search triplet.
    always_comb begin
        st_n      = state;
        ph_n      = phase;
        idx_step  = 1'b0;
        idx_clear = 1'b0;
        if (bus_reset) begin
            st_n      = ST_CMD;
            ph_n      = PH_TRUE;
            idx_clear = 1'b1;
        end else begin
            unique case (state)
                ST_CMD: begin
                    if (cmd_done) begin
                        idx_clear = 1'b1;
                        ph_n      = PH_TRUE;
                        unique case (cmd_code)
                            CMD_READ:   st_n = ST_READ;
                            CMD_MATCH:  st_n = ST_MATCH;
                            CMD_SKIP:   st_n = ST_SEL;
                            CMD_SEARCH: st_n = ST_SEARCH;
                            CMD_ALARM:  st_n = alarm_flag ? ST_SEARCH : ST_MUTE;
                            default:    st_n = ST_MUTE;
                        endcase
                    end
                end
                ST_READ: begin
                    if (rd_req) begin
                        idx_step = 1'b1;
                        if (idx_last) st_n = ST_SEL;
                    end
                end
                ST_MATCH: begin
                    if (wr_stb) begin
                        if (wr_bit != id_bit) begin
                            st_n = ST_MUTE;
                        end else begin
                            idx_step = 1'b1;
                            if (idx_last) st_n = ST_SEL;
                        end
                    end
                end
                ST_SEARCH: begin
                    unique case (phase)
                        PH_TRUE: if (rd_req) ph_n = PH_COMP;
                        PH_COMP: if (rd_req) ph_n = PH_DIR;
                        PH_DIR: begin
                            if (wr_stb) begin
                                if (wr_bit != id_bit || idx_last) begin
                                    st_n = ST_MUTE;
                                end else begin
                                    idx_step = 1'b1;
                                    ph_n     = PH_TRUE;
                                end
                            end
                        end
                        default: ph_n = PH_TRUE;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // State and phase registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_CMD;
            phase <= PH_TRUE;
        end else begin
            state <= st_n;
            phase <= ph_n;
        end
    end

    // Pass-through register toward the function layer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fn_bit_valid <= 1'b0;
            fn_bit       <= 1'b0;
        end else begin
            fn_bit_valid <= wr_stb && !bus_reset && (state == ST_SEL);
            if (wr_stb) fn_bit <= wr_bit;
        end
    end

    // Read-slot answer: identity bits only while exchanging, else release.
    always_comb begin
        unique case (state)
            ST_READ:   rd_bit = id_bit;
            ST_SEARCH: rd_bit = (phase == PH_TRUE) ? id_bit :
                                (phase == PH_COMP) ? ~id_bit : 1'b1;
            default:   rd_bit = 1'b1;
        endcase
    end

    // Command bits are taken only while collecting.
    always_comb begin
        cmd_shift = wr_stb && !bus_reset && (state == ST_CMD);
        selected  = (state == ST_SEL);
    end

endmodule

// File: rtl/ow_rom_layer.sv
// Module ow_rom_layer
// Top of the addressing layer. Builds the fixed identity from the family
// and serial parameters and wires the command collector, the identity bit
// pointer and the sequencer together. Assumes decoded one-cycle slot strobes.
module ow_rom_layer
    import ow_rom_pkg::*;
#(
    parameter logic [FAM_W-1:0] FAMILY = 8'h10,
    parameter logic [SER_W-1:0] SERIAL = 48'h00A1_B2C3_D4E5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset,
    input  logic wr_stb,
    input  logic wr_bit,
    input  logic rd_req,
    input  logic alarm_flag,
    output logic rd_bit,
    output logic selected,
    output logic fn_bit_valid,
    output logic fn_bit
);
    localparam logic [ID_W-1:0] IDENT = build_id(FAMILY, SERIAL);

    logic             cmd_shift, cmd_done;
    logic [CMD_W-1:0] cmd_code;
    logic             idx_clear, idx_step, idx_last;
    logic [IDX_W-1:0] idx;
    logic             id_bit;
    rom_state_e       fsm_state;

    ow_cmd_collect #(.CMD_W(CMD_W)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (bus_reset),
        .shift_en (cmd_shift),
        .bit_in   (wr_bit),
        .done     (cmd_done),
        .code     (cmd_code)
    );

    ow_id_index #(.ID_W(ID_W)) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (idx_clear),
        .step  (idx_step),
        .idx   (idx),
        .last  (idx_last)
    );

    // Identity bit under the pointer.
    always_comb id_bit = IDENT[idx];

    ow_rom_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_reset    (bus_reset),
        .wr_stb       (wr_stb),
        .wr_bit       (wr_bit),
        .rd_req       (rd_req),
        .alarm_flag   (alarm_flag),
        .cmd_done     (cmd_done),
        .cmd_code     (cmd_code),
        .id_bit       (id_bit),
        .idx_last     (idx_last),
        .cmd_shift    (cmd_shift),
        .idx_clear    (idx_clear),
        .idx_step     (idx_step),
        .state        (fsm_state),
        .rd_bit       (rd_bit),
        .selected     (selected),
        .fn_bit_valid (fn_bit_valid),
        .fn_bit       (fn_bit)
    );

endmodule

// File: rtl/ow_rom_layer_chk.sv
// Module ow_rom_layer_chk
// Cycle invariants of the addressing layer, bound into every ow_rom_layer.
module ow_rom_layer_chk
    import ow_rom_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_reset,
    input logic       wr_stb,
    input logic       wr_bit,
    input logic       rd_req,
    input logic       rd_bit,
    input logic       selected,
    input logic       fn_bit_valid,
    input logic       fn_bit,
    input rom_state_e state
);
    AST_BUS_RESET_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (!selected && !fn_bit_valid && rd_bit)); // R12

    AST_FN_AFTER_SELECTED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        fn_bit_valid |-> ($past(wr_stb) && $past(selected))); // R10

    AST_FN_CARRIES_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        fn_bit_valid |-> (fn_bit == $past(wr_bit))); // R10

    AST_MUTE_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MUTE) |-> rd_bit); // R5

    AST_MUTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_MUTE) && !bus_reset) |=> (state == ST_MUTE)); // R9

    AST_SELECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (selected && !bus_reset) |=> selected); // R4

    AST_SELECT_ON_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(selected) |-> ($past(wr_stb) || $past(rd_req))); // R6

    AST_IDLE_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_CMD) || selected) |-> rd_bit); // R11

endmodule

bind ow_rom_layer ow_rom_layer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_reset    (bus_reset),
    .wr_stb       (wr_stb),
    .wr_bit       (wr_bit),
    .rd_req       (rd_req),
    .rd_bit       (rd_bit),
    .selected     (selected),
    .fn_bit_valid (fn_bit_valid),
    .fn_bit       (fn_bit),
    .state        (fsm_state)
);

// File: tb/ow_rom_layer_test.sv
`timescale 1ns/1ps
module ow_rom_layer_test;
    localparam logic [7:0]  FAM = 8'h10;
    localparam logic [47:0] SER = 48'h00A1_B2C3_D4E5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_reset = 1'b0, wr_stb = 1'b0, wr_bit = 1'b0, rd_req = 1'b0, alarm_flag = 1'b0;
    logic rd_bit, selected, fn_bit_valid, fn_bit;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [63:0] exp_id;

    ow_rom_layer #(.FAMILY(FAM), .SERIAL(SER)) uut (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .wr_stb(wr_stb),
        .wr_bit(wr_bit), .rd_req(rd_req), .alarm_flag(alarm_flag),
        .rd_bit(rd_bit), .selected(selected), .fn_bit_valid(fn_bit_valid), .fn_bit(fn_bit)
    );

    always #2.5 clk = ~clk;

    function automatic logic [63:0] ref_id();
        logic [55:0] body;
        logic [7:0]  c;
        body = {SER, FAM};
        c = 8'h00;
        for (int i = 0; i < 56; i++) begin
            if (c[0] ^ body[i]) c = (c >> 1) ^ 8'h8C;
            else                c = c >> 1;
        end
        return {c, body};
    endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_reset();
        bus_reset = 1'b1; @(negedge clk); bus_reset = 1'b0;
    endtask

    task automatic wslot(input logic v);
        wr_bit = v; wr_stb = 1'b1; @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic rslot(output logic v);
        v = rd_bit; rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) wslot(b[i]);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic a, b;
        exp_id = ref_id();
        repeat (4) @(negedge clk);
        chk({selected, fn_bit_valid, rd_bit}, 3'b001, "R1 state during reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk({selected, fn_bit_valid, rd_bit}, 3'b001, "R1 state after reset");

        // Every command code with no alarm pending: R2 R6 R8 R9
        for (int c = 0; c < 256; c++) begin
            pulse_reset();
            send_byte(8'(c));
            chk(selected, (c == 8'hCC), "R2/R6 selection after command");
            rslot(a);
            chk(a, (c == 8'h33 || c == 8'hF0) ? exp_id[0] : 1'b1, "R2/R8/R9 first read answer");
            wslot(1'b1);
            chk(fn_bit_valid, (c == 8'hCC), "R9/R10 pass-through after command");
        end

        // Read ID stream: R3
        pulse_reset();
        send_byte(8'h33);
        for (int i = 0; i < 64; i++) begin
            chk(selected, 1'b0, "R3 not selected during read");
            rslot(a);
            chk(a, exp_id[i], "R3 identity bit");
        end
        chk(selected, 1'b1, "R3 selected after 64 reads");
        rslot(a);
        chk(a, 1'b1, "R11 read while selected");

        // Pass-through: R10
        for (int i = 0; i < 8; i++) begin
            wslot(8'hA5 >> i);
            chk({fn_bit_valid, fn_bit}, {1'b1, 1'((8'hA5 >> i) & 1)}, "R10 pass-through bit");
        end
        @(negedge clk);
        chk(fn_bit_valid, 1'b0, "R10 no pulse without slot");

        // Match ID exact: R4
        pulse_reset();
        send_byte(8'h55);
        for (int i = 0; i < 63; i++) wslot(exp_id[i]);
        chk(selected, 1'b0, "R4 not selected before last bit");
        wslot(exp_id[63]);
        chk(selected, 1'b1, "R4 selected after last bit");
        repeat (3) @(negedge clk);
        chk(selected, 1'b1, "R4 selection holds");

        // Match ID with one wrong bit at each position: R5
        for (int k = 0; k < 64; k++) begin
            pulse_reset();
            send_byte(8'h55);
            for (int i = 0; i < 64; i++) wslot(exp_id[i] ^ (i == k));
            chk(selected, 1'b0, "R5 mismatch not selected");
            rslot(a);
            chk(a, 1'b1, "R5 quiet read");
            wslot(1'b0);
            chk(fn_bit_valid, 1'b0, "R5 no pass-through");
        end
        pulse_reset();
        send_byte(8'hCC);
        chk(selected, 1'b1, "R12 recovery after quiet");

        // Full search: R7
        pulse_reset();
        send_byte(8'hF0);
        for (int i = 0; i < 64; i++) begin
            rslot(a); rslot(b);
            chk({a, b}, {exp_id[i], ~exp_id[i]}, "R7 bit and complement");
            wslot(exp_id[i]);
        end
        chk(selected, 1'b0, "R7 not selected after search");
        rslot(a);
        chk(a, 1'b1, "R7 quiet after search");

        // Search lost at chosen positions: R7
        for (int t = 0; t < 4; t++) begin
            int k;
            k = (t == 0) ? 0 : (t == 1) ? 5 : (t == 2) ? 40 : 63;
            pulse_reset();
            send_byte(8'hF0);
            for (int i = 0; i < k; i++) begin
                rslot(a); rslot(b); wslot(exp_id[i]);
            end
            rslot(a); rslot(b);
            chk({a, b}, {exp_id[k], ~exp_id[k]}, "R7 pair before loss");
            wslot(~exp_id[k]);
            rslot(a); rslot(b);
            chk({a, b}, 2'b11, "R7 released after loss");
        end

        // Alarm search with flag set: R8
        alarm_flag = 1'b1;
        pulse_reset();
        send_byte(8'hEC);
        for (int i = 0; i < 3; i++) begin
            rslot(a); rslot(b);
            chk({a, b}, {exp_id[i], ~exp_id[i]}, "R8 alarm search pair");
            wslot(exp_id[i]);
        end
        alarm_flag = 1'b0;

        // Bus reset mid-read and colliding with a write slot: R12
        pulse_reset();
        send_byte(8'h33);
        for (int i = 0; i < 10; i++) rslot(a);
        bus_reset = 1'b1; wr_stb = 1'b1; wr_bit = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0; wr_stb = 1'b0;
        chk({selected, fn_bit_valid, rd_bit}, 3'b001, "R12 reset wins over slot");
        for (int i = 0; i < 4; i++) wslot(1'b0);
        rslot(a);
        chk(a, 1'b1, "R11 read during command collection");
        for (int i = 4; i < 8; i++) wslot(8'hCC >> i);
        // half-byte 0000 then high nibble of CC gives C0h: unknown code
        chk(selected, 1'b0, "R9 unknown code C0h");
        pulse_reset();
        send_byte(8'hCC);
        chk(selected, 1'b1, "R6 skip after reset");

        // Synchronous reset mid-transaction: R1
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk({selected, rd_bit}, 2'b01, "R1 rst_n deselects");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule